// File: doc/BRIEF.md
# Raster Line and Frame Interrupt Generator

This block turns a raster position supplied by a separate video timing counter into the interrupt events a CPU needs to follow the display. It raises a frame flag once per frame, when the beam enters the lower border, and runs a programmable down-counter that requests an interrupt every N+1 active lines. It also gives the CPU a readable 8-bit vertical position. That position skips backwards in a pattern that depends on the active height and on the broadcast standard.

The timing counter presents `rowIn` and `colIn` together with a one-cycle `colAdvance` strobe each time the column moves on. The block reacts only to strobed positions. The CPU programs the reload value and the two enables, and pulses `statusRead` when it reads the status register, which acknowledges both interrupt sources. The active height is selected by `lineMode`: 0 selects 192 lines, 1 selects 224, 2 selects 240, and 3 behaves as 192. `palMode` selects 313 lines per frame; otherwise a frame has 262 lines.

Top module: `raster_irq_unit`

## Requirements
- R1: After reset, the frame flag, the pending line interrupt and `irqOut` are 0. The line down-counter holds 0xFF. The stored position is row 0, column 0.
- R2: A line check happens on a clock where `colAdvance` is high and `colIn` equals 64. If `rowIn` is at most the active height (0 to height inclusive), the counter decrements. When it would pass below 0, it instead reloads from `reloadValue` and sets the pending line interrupt.
- R3: At a line check on any row greater than the active height, the counter reloads from `reloadValue` and nothing is set.
- R4: The frame flag is set on a clock where `colAdvance` is high, `colIn` equals 63 and `rowIn` equals the active height plus 1. For example, this is row 193 in 192-line mode.
- R5: `irqOut` equals (frame flag AND `frameIrqEn`) OR (pending line interrupt AND `lineIrqEn`). The enables act at once and do not alter the flags.
- R6: `statusRead` clears the frame flag and the pending line interrupt on the next edge. A flag being set on that same edge stays set.
- R7: `rowIn` and `colIn` are stored only on `colAdvance`. `vCount` reflects the stored position from the cycle after the strobe, and does not respond to unstrobed input changes.
- R8: If the stored column is below 63, the reported source row is the previous row; row 0 maps to the last line of the frame (261 or 312). Otherwise it is the stored row.
- R9: With `palMode` = 0, a source row at or above 219 (192-line mode) or 235 (224-line mode) is reduced by 6. 240-line mode applies no reduction. The result is truncated to 8 bits.
- R10: With `palMode` = 1, a source row at or above 243 (192-line), 259 (224-line) or 267 (240-line) is reduced by 57. The result is truncated to 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| colAdvance | input | 1 | Raster column step strobe |
| rowIn | input | 9 | Current raster row |
| colIn | input | 9 | Current raster column (0 to 341) |
| lineMode | input | 2 | Active height select: 0=192, 1=224, 2=240, 3=192 |
| palMode | input | 1 | 1: 313-line frame, 0: 262-line frame |
| reloadValue | input | 8 | Line counter reload value |
| frameIrqEn | input | 1 | Frame interrupt enable |
| lineIrqEn | input | 1 | Line interrupt enable |
| statusRead | input | 1 | Status read acknowledge strobe |
| irqOut | output | 1 | Interrupt request |
| frameFlag | output | 1 | Frame interrupt status bit |
| vCount | output | 8 | Translated vertical counter |

## Verification
The bench drives the counter through underflow, with a small reload value, across the boundary between active and inactive rows. A design that decremented on border rows, or tested the height with strict less-than, would fire one line early or late. The frame row is probed one below and at the target row. A status read is issued on the very edge that sets a flag, and a design that let the clear win would drop that interrupt. `vCount` is probed exactly at each jump threshold, at the column 62/63 boundary and at row 0. A wrong comparison or a missing wrap to the last line shows up there as a value off by 6, 57 or one row.

// File: rtl/rik_pkg.sv
package rik_pkg;
  typedef enum logic [1:0] {
    LM_192 = 2'd0,
    LM_224 = 2'd1,
    LM_240 = 2'd2,
    LM_ALT = 2'd3
  } lineMode_e;

  typedef struct packed {
    logic lineTick;
    logic lineActive;
    logic frameTick;
    logic latchPos;
  } ctlStrobe_t;

  function automatic logic [8:0] activeRows(input logic [1:0] m);
    case (m)
      LM_224:  activeRows = 9'd224;
      LM_240:  activeRows = 9'd240;
      default: activeRows = 9'd192;
    endcase
  endfunction
endpackage

// File: rtl/rik_control.sv
module rik_control
  import rik_pkg::*;
#(
  parameter int ROW_W = 9,
  parameter int COL_W = 9,
  parameter int LINE_COL = 64,
  parameter int FRAME_COL = 63
) (
  input  logic             colAdvance,
  input  logic [ROW_W-1:0] rowIn,
  input  logic [COL_W-1:0] colIn,
  input  logic [1:0]       lineMode,
  output ctlStrobe_t       strobe
);
  localparam logic [COL_W-1:0] LINE_AT  = COL_W'(LINE_COL);
  localparam logic [COL_W-1:0] FRAME_AT = COL_W'(FRAME_COL);

  logic [ROW_W-1:0] pixRows;

  always_comb begin
    pixRows = ROW_W'(activeRows(lineMode));
    strobe.latchPos   = colAdvance;
    strobe.lineTick   = colAdvance && (colIn == LINE_AT);
    strobe.lineActive = (rowIn <= pixRows);
    strobe.frameTick  = colAdvance && (colIn == FRAME_AT) && (rowIn == pixRows + ROW_W'(1));
  end
endmodule

// File: rtl/rik_datapath.sv
module rik_datapath
  import rik_pkg::*;
#(
  parameter int ROW_W = 9,
  parameter int COL_W = 9,
  parameter int CNT_W = 8,
  parameter int VC_W = 8,
  parameter int NTSC_LINES = 262,
  parameter int PAL_LINES = 313,
  parameter int VC_SWITCH_COL = 63
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctlStrobe_t       strobe,
  input  logic [ROW_W-1:0] rowIn,
  input  logic [COL_W-1:0] colIn,
  input  logic [1:0]       lineMode,
  input  logic             palMode,
  input  logic [CNT_W-1:0] reloadValue,
  input  logic             frameIrqEn,
  input  logic             lineIrqEn,
  input  logic             statusRead,
  output logic             irqOut,
  output logic             frameFlag,
  output logic [VC_W-1:0]  vCount
);
  localparam logic [ROW_W-1:0] NTSC_LAST = ROW_W'(NTSC_LINES - 1);
  localparam logic [ROW_W-1:0] PAL_LAST  = ROW_W'(PAL_LINES - 1);
  localparam logic [COL_W-1:0] VC_COL    = COL_W'(VC_SWITCH_COL);
  localparam logic [ROW_W-1:0] NTSC_STEP = ROW_W'(6);
  localparam logic [ROW_W-1:0] PAL_STEP  = ROW_W'(57);

  logic [CNT_W-1:0] lineCnt;
  logic             linePending;
  logic [ROW_W-1:0] rowQ;
  logic [COL_W-1:0] colQ;
  logic             cntWrap;

  assign cntWrap = (lineCnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lineCnt     <= '1;
      linePending <= 1'b0;
      frameFlag   <= 1'b0;
      rowQ        <= '0;
      colQ        <= '0;
    end else begin
      if (strobe.lineTick) begin
        if (!strobe.lineActive || cntWrap) lineCnt <= reloadValue;
        else                               lineCnt <= lineCnt - CNT_W'(1);
      end
      if (strobe.lineTick && strobe.lineActive && cntWrap) linePending <= 1'b1;
      else if (statusRead)                                 linePending <= 1'b0;
      if (strobe.frameTick)  frameFlag <= 1'b1;
      else if (statusRead)   frameFlag <= 1'b0;
      if (strobe.latchPos) begin
        rowQ <= rowIn;
        colQ <= colIn;
      end
    end
  end

  assign irqOut = (frameFlag && frameIrqEn) || (linePending && lineIrqEn);

  logic [ROW_W-1:0] srcRow;
  logic [ROW_W-1:0] adjRow;
  logic [ROW_W-1:0] thresh;
  logic             useAdj;

  always_comb begin
    if (colQ < VC_COL) begin
      if (rowQ == '0) srcRow = palMode ? PAL_LAST : NTSC_LAST;
      else            srcRow = rowQ - ROW_W'(1);
    end else begin
      srcRow = rowQ;
    end
    useAdj = 1'b1;
    if (!palMode) begin
      case (lineMode)
        LM_224:  thresh = ROW_W'(235);
        LM_240:  begin thresh = '1; useAdj = 1'b0; end
        default: thresh = ROW_W'(219);
      endcase
    end else begin
      case (lineMode)
        LM_224:  thresh = ROW_W'(259);
        LM_240:  thresh = ROW_W'(267);
        default: thresh = ROW_W'(243);
      endcase
    end
    if (useAdj && srcRow >= thresh) adjRow = srcRow - (palMode ? PAL_STEP : NTSC_STEP);
    else                            adjRow = srcRow;
    vCount = adjRow[VC_W-1:0];
  end
endmodule

// File: rtl/raster_irq_unit.sv
module raster_irq_unit
  import rik_pkg::*;
#(
  parameter int ROW_W = 9,
  parameter int COL_W = 9,
  parameter int CNT_W = 8,
  parameter int VC_W = 8,
  parameter int LINE_COL = 64,
  parameter int FRAME_COL = 63,
  parameter int VC_SWITCH_COL = 63,
  parameter int NTSC_LINES = 262,
  parameter int PAL_LINES = 313
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             colAdvance,
  input  logic [ROW_W-1:0] rowIn,
  input  logic [COL_W-1:0] colIn,
  input  logic [1:0]       lineMode,
  input  logic             palMode,
  input  logic [CNT_W-1:0] reloadValue,
  input  logic             frameIrqEn,
  input  logic             lineIrqEn,
  input  logic             statusRead,
  output logic             irqOut,
  output logic             frameFlag,
  output logic [VC_W-1:0]  vCount
);
  ctlStrobe_t strobe;

  rik_control #(
    .ROW_W(ROW_W), .COL_W(COL_W), .LINE_COL(LINE_COL), .FRAME_COL(FRAME_COL)
  ) i_control (
    .colAdvance(colAdvance), .rowIn(rowIn), .colIn(colIn),
    .lineMode(lineMode), .strobe(strobe)
  );

  rik_datapath #(
    .ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W), .VC_W(VC_W),
    .NTSC_LINES(NTSC_LINES), .PAL_LINES(PAL_LINES), .VC_SWITCH_COL(VC_SWITCH_COL)
  ) i_datapath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rowIn(rowIn), .colIn(colIn),
    .lineMode(lineMode), .palMode(palMode), .reloadValue(reloadValue),
    .frameIrqEn(frameIrqEn), .lineIrqEn(lineIrqEn), .statusRead(statusRead),
    .irqOut(irqOut), .frameFlag(frameFlag), .vCount(vCount)
  );
endmodule

// File: rtl/raster_irq_unit_chk.sv
module raster_irq_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       colAdvance,
  input logic [1:0] lineMode,
  input logic       palMode,
  input logic       frameIrqEn,
  input logic       lineIrqEn,
  input logic       statusRead,
  input logic       irqOut,
  input logic       frameFlag,
  input logic [7:0] vCount
);
  a_r5_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (!frameIrqEn && !lineIrqEn) |-> !irqOut);

  a_r5_frame_drives_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (frameFlag && frameIrqEn) |-> irqOut);

  a_r6_read_clears_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (statusRead && !colAdvance) |=> !frameFlag);

  a_r4_frame_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frameFlag) |-> $past(colAdvance));

  a_r2_line_irq_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irqOut) && !frameIrqEn && $stable(lineIrqEn)) |-> $past(colAdvance));

  a_r7_vcount_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(colAdvance) && $stable(palMode) && $stable(lineMode)) |-> $stable(vCount));
endmodule

bind raster_irq_unit raster_irq_unit_chk i_chk (
  .clk(clk), .rst_n(rst_n), .colAdvance(colAdvance), .lineMode(lineMode),
  .palMode(palMode), .frameIrqEn(frameIrqEn), .lineIrqEn(lineIrqEn),
  .statusRead(statusRead), .irqOut(irqOut), .frameFlag(frameFlag), .vCount(vCount)
);

// File: tb/test_raster_irq_unit.sv
module test_raster_irq_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       colAdvance = 1'b0;
  logic [8:0] rowIn = '0;
  logic [8:0] colIn = '0;
  logic [1:0] lineMode = 2'd0;
  logic       palMode = 1'b0;
  logic [7:0] reloadValue = '0;
  logic       frameIrqEn = 1'b0;
  logic       lineIrqEn = 1'b0;
  logic       statusRead = 1'b0;
  logic       irqOut, frameFlag;
  logic [7:0] vCount;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int mCnt, mRow, mCol;
  bit mFrame, mPend;

  always #5 clk = ~clk;

  raster_irq_unit i_raster_irq_unit (
    .clk(clk), .rst_n(rst_n), .colAdvance(colAdvance), .rowIn(rowIn), .colIn(colIn),
    .lineMode(lineMode), .palMode(palMode), .reloadValue(reloadValue),
    .frameIrqEn(frameIrqEn), .lineIrqEn(lineIrqEn), .statusRead(statusRead),
    .irqOut(irqOut), .frameFlag(frameFlag), .vCount(vCount)
  );

  function automatic int heightOf(input int m);
    return (m == 1) ? 224 : (m == 2) ? 240 : 192;
  endfunction

  function automatic int vcExpect(input int r, input int c, input int pal, input int m);
    int s;
    s = (c < 63) ? ((r == 0) ? (pal ? 312 : 261) : r - 1) : r;
    if (!pal) begin
      if (m == 1) begin if (s >= 235) s -= 6; end
      else if (m != 2) begin if (s >= 219) s -= 6; end
    end else begin
      if (m == 1) begin if (s >= 259) s -= 57; end
      else if (m == 2) begin if (s >= 267) s -= 57; end
      else begin if (s >= 243) s -= 57; end
    end
    return s & 255;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    int expIrq;
    expIrq = ((mFrame && frameIrqEn) || (mPend && lineIrqEn)) ? 1 : 0;
    check({tag, " R5 irqOut"}, int'(irqOut), expIrq);
    check({tag, " R4/R6 frameFlag"}, int'(frameFlag), int'(mFrame));
    check({tag, " R8/R9/R10 vCount"}, int'(vCount), vcExpect(mRow, mCol, palMode, lineMode));
  endtask

  task automatic step(input string tag, input bit adv, input int r, input int c, input bit rd);
    int h;
    bit fSet, pSet;
    colAdvance = adv; rowIn = 9'(r); colIn = 9'(c); statusRead = rd;
    @(posedge clk);
    h = heightOf(lineMode);
    fSet = 0; pSet = 0;
    if (adv && c == 64) begin
      if (r <= h) begin
        if (mCnt == 0) begin pSet = 1; mCnt = reloadValue; end
        else mCnt = mCnt - 1;
      end else mCnt = reloadValue;
    end
    if (adv && c == 63 && r == h + 1) fSet = 1;
    mFrame = fSet ? 1 : (rd ? 0 : mFrame);
    mPend  = pSet ? 1 : (rd ? 0 : mPend);
    if (adv) begin mRow = r; mCol = c; end
    #1;
    compareAll(tag);
    @(negedge clk);
    colAdvance = 0; statusRead = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    mCnt = 255; mRow = 0; mCol = 0; mFrame = 0; mPend = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1;
    check("R1 irqOut", int'(irqOut), 0);
    check("R1 frameFlag", int'(frameFlag), 0);
    check("R1 vCount", int'(vCount), 255);
    @(negedge clk);

    // R3 then R2: reload on border row, count down across active rows
    lineIrqEn = 1; reloadValue = 8'd2;
    step("R3 reload", 1, 200, 64, 0);
    step("R2 dec", 1, 0, 64, 0);
    check("R2 no irq yet", int'(irqOut), 0);
    step("R2 dec", 1, 1, 64, 0);
    check("R2 no irq at zero", int'(irqOut), 0);
    step("R2 wrap", 1, 2, 64, 0);
    check("R2 irq on wrap", int'(irqOut), 1);
    step("R6 ack", 0, 2, 64, 1);
    check("R6 line cleared", int'(irqOut), 0);
    step("R2 top row", 1, 192, 64, 0);
    step("R2 wrap row", 1, 193, 64, 0);
    check("R3 border row no irq", int'(irqOut), 0);

    // R4 frame flag position
    lineIrqEn = 0; frameIrqEn = 1;
    step("R4 row192", 1, 192, 63, 0);
    check("R4 not on row 192", int'(frameFlag), 0);
    step("R4 row193", 1, 193, 63, 0);
    check("R4 set on row 193", int'(frameFlag), 1);
    check("R5 irq follows", int'(irqOut), 1);
    frameIrqEn = 0; #1;
    check("R5 enable gates", int'(irqOut), 0);
    step("R6 clear", 0, 193, 63, 1);
    check("R6 frame cleared", int'(frameFlag), 0);
    step("R6 set wins", 1, 193, 63, 1);
    check("R6 set beats read", int'(frameFlag), 1);

    // R7 unstrobed change ignored
    step("R7 latch", 1, 100, 100, 0);
    step("R7 no latch", 0, 250, 10, 0);
    check("R7 vCount held", int'(vCount), 100);

    // R8/R9/R10 corner values
    palMode = 0; lineMode = 2'd0;
    step("R9 at 219", 1, 219, 100, 0);  check("R9 219", int'(vCount), 213);
    step("R9 at 218", 1, 218, 100, 0);  check("R9 218", int'(vCount), 218);
    step("R8 row0", 1, 0, 10, 0);       check("R8 wrap", int'(vCount), 255);
    step("R8 col62", 1, 5, 62, 0);      check("R8 prev", int'(vCount), 4);
    lineMode = 2'd2;
    step("R9 240", 1, 261, 100, 0);     check("R9 240", int'(vCount), 5);
    palMode = 1; lineMode = 2'd1;
    step("R10 259", 1, 259, 100, 0);    check("R10 259", int'(vCount), 202);
    lineMode = 2'd2;
    step("R10 267", 1, 267, 100, 0);    check("R10 267", int'(vCount), 210);
    lineMode = 2'd0;
    step("R10 243", 1, 243, 100, 0);    check("R10 243", int'(vCount), 186);
    step("R8 pal row0", 1, 0, 0, 0);    check("R8 pal wrap", int'(vCount), 255);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r, c, tot, h, pick;
      if ($urandom_range(0, 99) < 3) palMode = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 99) < 3) lineMode = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 99) < 10) frameIrqEn = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 99) < 10) lineIrqEn = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 99) < 5) reloadValue = 8'($urandom_range(0, 3));
      tot = palMode ? 313 : 262;
      h = heightOf(lineMode);
      pick = $urandom_range(0, 9);
      if (pick < 4) r = $urandom_range(0, h + 2 < tot ? h + 2 : tot - 1);
      else if (pick < 6) r = h - 1 + $urandom_range(0, 3);
      else r = $urandom_range(0, tot - 1);
      pick = $urandom_range(0, 4);
      c = (pick == 0) ? 62 : (pick == 1) ? 63 : (pick == 2) ? 64 : $urandom_range(0, 341);
      step("rand", ($urandom_range(0, 99) < 70), r, c, ($urandom_range(0, 99) < 15));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule